// File: doc/BRIEF.md
# Three-Wire Serial Register Port

A slave port that lets a host reach a bank of eight 8-bit control registers over three wires: a serial clock, an active-low chip select and one data line. The host lowers chip select and sends a 14-bit command word, most significant bit first. The word holds a 2-bit operation code, a 3-bit register address and a 9-bit data field. The first bit of the data field is a spare slot that carries no register content, so eight payload bits remain. A write stores the payload in the addressed register when the 14th bit arrives. A read turns the data line around and returns the addressed register in the data field.

The port runs on the device's own clock. The serial clock, chip select and serial input each pass through a two-flop synchronizer, and edges are detected after it. Each high phase and each low phase of the serial clock must therefore last at least three device clock cycles. All registers appear in parallel on `reg_out`. Register `a` occupies bits `[8a+7:8a]`.

Top module: `tri_wire_regfile`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, every register reads zero on `reg_out` and `sd_oe` is low.
- R2: A frame begins with `cs_n` low. `sd_i` is sampled on each rising serial-clock edge in this order: op code (2 bits), address (3 bits), one spare bit, then 8 data bits, each field MSB first. With op code 2'b01 the 8 data bits are written to the addressed register at the 14th rising edge. All other registers keep their values.
- R3: With op code 2'b10, `sd_oe` rises at the first falling serial-clock edge after the 5th rising edge. At each falling edge from that one on, `sd_o` takes a new value: first 0 for the spare slot, then the addressed register MSB first. A read changes no register.
- R4: Op codes 2'b00 and 2'b11 change no register and never assert `sd_oe`.
- R5: If `cs_n` rises before the 14th rising edge, the frame is dropped and no register changes.
- R6: `sd_oe` stays low during write frames and outside the read data phase. It is released within a few clock cycles of `cs_n` going high.
- R7: If the rise of `cs_n` and the 14th rising serial-clock edge reach the synchronized domain in the same clock cycle, the frame is treated as dropped and no write occurs.
- R8: Rising edges after the 14th within the same frame are ignored. The bit counter holds at 14 and the written value stays as set by the first 14 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sd_i | input | 1 | Serial data from host |
| sd_o | output | 1 | Serial data to host during reads |
| sd_oe | output | 1 | Output enable for the shared data line |
| reg_out | output | 64 | All eight registers, register a at [8a+7:8a] |

## Verification
The write commit at the 14th rising serial-clock edge and the release of chip select can land in the same synchronized clock cycle. The bench provokes this by raising the serial clock and chip select in the same time step on the last bit of a write frame. It judges the outcome from `reg_out`: the register must keep its old value, and a normal resend of the same frame must then change it. Full write and read sweeps over all eight addresses, the ignored op codes and the truncated frames are compared against a register model kept in the bench.

// File: rtl/tri_wire_regfile.sv
module tri_wire_regfile #(
  parameter int INSTR_W = 2,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int SYNC    = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sclk,
  input  logic                                cs_n,
  input  logic                                sd_i,
  output logic                                sd_o,
  output logic                                sd_oe,
  output logic [(1<<ADDR_W)*DATA_W-1:0]       reg_out
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int HDR   = INSTR_W + ADDR_W;
  localparam int FRAME = HDR + 1 + DATA_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] HDR_C   = CW'(HDR);
  localparam logic [CW-1:0] HDR_M1  = CW'(HDR - 1);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME);
  localparam logic [CW-1:0] LAST_C  = CW'(FRAME - 1);
  localparam logic [INSTR_W-1:0] OP_WR = INSTR_W'(1);
  localparam logic [INSTR_W-1:0] OP_RD = INSTR_W'(2);

  logic [SYNC-1:0] sclk_s, cs_s, sd_s;
  logic            sclk_d;
  logic [FRAME-2:0] sh;
  logic [CW-1:0]   cnt;
  logic [INSTR_W-1:0] op_q;
  logic [ADDR_W-1:0]  adr_q;
  logic [DATA_W:0]    rdsh;
  logic [DATA_W-1:0]  regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '1;
      cs_s   <= '1;
      sd_s   <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC-2:0], sclk};
      cs_s   <= {cs_s[SYNC-2:0], cs_n};
      sd_s   <= {sd_s[SYNC-2:0], sd_i};
      sclk_d <= sclk_s[SYNC-1];
    end

  wire sclk_q = sclk_s[SYNC-1];
  wire cs_q   = cs_s[SYNC-1];
  wire sd_q   = sd_s[SYNC-1];
  wire rise   = sclk_q & ~sclk_d;
  wire fall   = ~sclk_q & sclk_d;
  wire sel    = ~cs_q;

  wire [FRAME-1:0] word = {sh, sd_q};
  wire take     = sel & rise & (cnt < FRAME_C);
  wire hdr_done = take & (cnt == HDR_M1);
  wire last     = take & (cnt == LAST_C);
  wire rd_slot  = sel & fall & (op_q == OP_RD) & (cnt >= HDR_C) & (cnt < FRAME_C);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      op_q  <= '0;
      adr_q <= '0;
      rdsh  <= '0;
    end else if (!sel) begin
      cnt  <= '0;
      op_q <= '0;
    end else begin
      if (take) begin
        sh  <= word[FRAME-2:0];
        cnt <= cnt + 1'b1;
      end
      if (hdr_done) begin
        op_q  <= word[HDR-1:ADDR_W];
        adr_q <= word[ADDR_W-1:0];
        rdsh  <= {1'b0, regs[word[ADDR_W-1:0]]};
      end else if (rd_slot) begin
        rdsh <= {rdsh[DATA_W-1:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sd_o  <= 1'b0;
      sd_oe <= 1'b0;
    end else if (!sel) begin
      sd_oe <= 1'b0;
    end else if (rd_slot) begin
      sd_o  <= rdsh[DATA_W];
      sd_oe <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (last && op_q == OP_WR) begin
      regs[adr_q] <= word[DATA_W-1:0];
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_out[g*DATA_W +: DATA_W] = regs[g];
  end

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && $past(cs_q)) |-> !sd_oe);
  // R4
  ignored_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && op_q != OP_WR) |=> $stable(reg_out));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> $stable(reg_out));
  // R3
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (op_q == OP_RD));
  // R3
  read_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> (cnt == HDR_C && !sd_o));
  // R8
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FRAME_C);
endmodule

// File: tb/tri_wire_regfile_test.sv
module tri_wire_regfile_test;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, sclk = 1, cs_n = 1, sd_i = 0;
  logic sd_o, sd_oe;
  logic [63:0] reg_out;

  tri_wire_regfile uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe), .reg_out(reg_out));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] mdl [8];
  logic [7:0] got;
  logic dummy_got;
  bit oe_hdr_bad, oe_data_bad;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_vec();
    logic [63:0] v;
    for (int a = 0; a < 8; a++) v[a*8 +: 8] = mdl[a];
    return v;
  endfunction

  task automatic frame(input logic [1:0] op, input logic [2:0] adr, input logic [7:0] dat,
                       input int nbits, input bit coincide);
    logic [13:0] w;
    w = {op, adr, 1'b0, dat};
    got = '0; dummy_got = 1; oe_hdr_bad = 0; oe_data_bad = 0;
    @(negedge clk);
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 0;
      sd_i = (i < 14) ? w[13-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 5 && sd_oe) oe_hdr_bad = 1;
      if (i >= 5 && i < 14) begin
        if (!sd_oe) oe_data_bad = 1;
        if (i == 5) dummy_got = sd_o;
        else got[13-i] = sd_o;
      end
      sclk = 1;
      if (coincide && i == 13) cs_n = 1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1;
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    frame(2'b01, a, d, 14, 0);
    mdl[a] = d;
    chk(reg_out == model_vec(), "R2 write", reg_out, model_vec());
    chk(!oe_hdr_bad && sd_oe == 0, "R6 oe low in write", {oe_hdr_bad, sd_oe}, 0);
  endtask

  task automatic rd(input logic [2:0] a);
    frame(2'b10, a, 8'h00, 14, 0);
    chk(got == mdl[a], "R3 read data", got, mdl[a]);
    chk(dummy_got == 0 && !oe_hdr_bad && !oe_data_bad, "R3 read shape",
        {dummy_got, oe_hdr_bad, oe_data_bad}, 0);
    chk(reg_out == model_vec(), "R3 read no change", reg_out, model_vec());
    chk(sd_oe == 0, "R6 oe released", sd_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 8; a++) mdl[a] = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(reg_out == 0 && sd_oe == 0, "R1 reset", {reg_out[62:0], sd_oe}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(reg_out == 0 && sd_oe == 0, "R1 after release", {reg_out[62:0], sd_oe}, 0);

    for (int a = 0; a < 8; a++) wr(3'(a), 8'((a * 53 + 29) & 255));
    for (int a = 0; a < 8; a++) rd(3'(a));

    foreach (mdl[k]) ;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pv;
      pv = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hAA : 8'h55;
      wr(3'd0, pv); rd(3'd0);
      wr(3'd7, ~pv); rd(3'd7);
    end

    // R4: codes 00 and 11 ignored
    for (int a = 0; a < 8; a++) begin
      frame(2'b00, 3'(a), ~mdl[a], 14, 0);
      chk(reg_out == model_vec() && !oe_hdr_bad && oe_data_bad, "R4 code 00",
          reg_out, model_vec());
      frame(2'b11, 3'(a), ~mdl[a], 14, 0);
      chk(reg_out == model_vec() && !oe_hdr_bad && oe_data_bad, "R4 code 11",
          reg_out, model_vec());
    end

    // R5: truncated frames
    for (int n = 1; n < 14; n += 3) begin
      frame(2'b01, 3'd3, ~mdl[3], n, 0);
      chk(reg_out == model_vec(), "R5 abort", reg_out, model_vec());
    end
    frame(2'b01, 3'd3, ~mdl[3], 13, 0);
    chk(reg_out == model_vec(), "R5 abort at 13", reg_out, model_vec());

    // R7: chip select release coincides with last edge
    frame(2'b01, 3'd5, ~mdl[5], 14, 1);
    chk(reg_out == model_vec(), "R7 coincident release", reg_out, model_vec());
    wr(3'd5, ~mdl[5]);

    // R8: extra edges ignored
    frame(2'b01, 3'd2, 8'h3C, 17, 0);
    mdl[2] = 8'h3C;
    chk(reg_out == model_vec(), "R8 extra bits", reg_out, model_vec());
    rd(3'd2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule